// File: doc/BRIEF.md
# Signed Integer to Extended-Float Stack Loader

This block turns a signed integer of 16, 32 or 64 bits into an exact 80-bit extended-precision floating-point value and pushes it onto an eight-entry floating-point register stack. The operand width is chosen from the opcode byte and the 3-bit register field of the instruction. The conversion never rounds. The 64-bit significand carries an explicit integer bit, so every supported integer fits in it without loss.

The block owns the stack state: the 3-bit top pointer, a 2-bit tag per physical register, the condition flag C1 and a one-cycle stack-fault pulse. Each push first moves the top pointer down by one, wrapping modulo 8, and then writes the new ST(0). If that register is still in use, the push is an overflow. The register then gets the quiet NaN indefinite value in place of the converted number, and C1 and the fault output report the overflow. The whole stack is brought out on ports so that it can be observed.

Top module: `int2ext_loader`

## Requirements
- R1: With `load_i` high, opcode 0xDF with register field 0 takes `operand_i[15:0]` as a signed 16-bit value. Opcode 0xDB with register field 0 takes `operand_i[31:0]` as a signed 32-bit value. Opcode 0xDF with register field 5 takes all 64 bits. Operand bits above the chosen width are ignored.
- R2: A load strobe with any other opcode/register-field pair has no effect: top, tags, register contents and C1 keep their values, and the fault output stays low.
- R3: The result word has the sign in bit 79 and a 15-bit exponent in bits 78:64 with bias 16383. Bits 63:0 hold the significand, which is the integer's magnitude shifted left until bit 63 is set. The exponent is 16383 plus the position of the magnitude's highest set bit.
- R4: The most negative value of each width converts exactly. -32768 gives 0xC00E_8000000000000000 and -2^63 gives 0xC03E_8000000000000000.
- R5: A zero operand yields an all-zero 80-bit word, and that register's tag becomes "zero".
- R6: After reset the top pointer is 0, every tag is empty, every register is 0, and C1 and the fault output are 0.
- R7: A push decrements the top pointer modulo 8 and writes physical register `top-1`. The new top, the register and its tag are visible on the ports one clock after the strobe.
- R8: Tags are 2 bits per register at `tags_o[2i+1:2i]`, with the encodings 00 = valid nonzero, 01 = zero, 11 = empty.
- R9: If the target register's tag is not empty, the push still moves the top pointer. The register receives 0xFFFF_C000000000000000 with tag valid, C1 becomes 1, and the fault output is high for exactly the one cycle after the strobe.
- R10: A push into an empty register clears C1 and leaves the fault output low.
- R11: In a cycle without a load strobe, top, tags, registers and C1 hold their values, and the fault output is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load strobe, one push per high cycle |
| opcode_i | input | 8 | Opcode byte of the instruction |
| reg_sel_i | input | 3 | Register field of the instruction's addressing byte |
| operand_i | input | 64 | Integer operand, low bits used for narrow widths |
| top_o | output | 3 | Stack top pointer (physical index of ST(0)) |
| c1_o | output | 1 | Condition flag C1, set by an overflowing push |
| stack_fault_o | output | 1 | Invalid-operation stack-fault pulse |
| tags_o | output | 16 | Per-register tags, 2 bits each |
| regs_o | output | 640 | Physical register contents, register i at bits 80i+79:80i |

## Verification
Every result of a push or an ignored strobe is due exactly one clock after the edge that samples the strobe: top, the written register, its tag, C1 and the fault pulse all become visible together. The driver sets inputs at a falling edge and tags each expected item with the cycle number one rising edge ahead. The monitor compares an item only at the falling edge of that cycle, so every comparison reads settled outputs. Back-to-back strobes, idle cycles after an overflow, and reset all use the same one-cycle timing. The fault pulse is therefore checked both in the cycle it is due and in the cycle after, when it must have fallen.

// File: rtl/ixl_pkg.sv
package ixl_pkg;

   // fixed width of the widest integer operand
   localparam int INT_W = 64;

   // operand size chosen by the decoder
   typedef enum logic [1:0] {
      SZ_NONE = 2'd0,
      SZ_W16  = 2'd1,
      SZ_W32  = 2'd2,
      SZ_W64  = 2'd3
   } isize_e;

   // register tag encodings
   localparam logic [1:0] TAG_VALID = 2'b00;
   localparam logic [1:0] TAG_ZERO  = 2'b01;
   localparam logic [1:0] TAG_EMPTY = 2'b11;

endpackage

// File: rtl/ixl_size_decode.sv
module ixl_size_decode
   import ixl_pkg::*;
#(
   parameter int          OPC_W       = 8,
   parameter int          FLD_W       = 3,
   parameter logic [7:0]  OPC_SHORT   = 8'hDF,
   parameter logic [7:0]  OPC_MID     = 8'hDB,
   parameter logic [2:0]  FLD_NARROW  = 3'd0,
   parameter logic [2:0]  FLD_WIDE    = 3'd5
) (
   input  logic [OPC_W-1:0] opcode_i,
   input  logic [FLD_W-1:0] field_i,
   output isize_e           size_o
);

   initial begin
      opc_width_chk: assert (OPC_W == 8 && FLD_W == 3)
         else $error("ixl_size_decode: opcode must be 8 bits and field 3 bits");
   end

   logic is_short_op;
   logic is_mid_op;

   assign is_short_op = (opcode_i == OPC_SHORT);
   assign is_mid_op   = (opcode_i == OPC_MID);

   always_comb begin
      size_o = SZ_NONE;
      if (is_short_op && field_i == FLD_NARROW)
         size_o = SZ_W16;
      else if (is_mid_op && field_i == FLD_NARROW)
         size_o = SZ_W32;
      else if (is_short_op && field_i == FLD_WIDE)
         size_o = SZ_W64;
   end

endmodule

// File: rtl/ixl_int_convert.sv
module ixl_int_convert
   import ixl_pkg::*;
#(
   parameter int EXP_W     = 15,
   parameter int SIG_W     = 64,
   parameter bit LZC_SPLIT = 1'b1,
   localparam int WORD_W   = 1 + EXP_W + SIG_W
) (
   input  isize_e             size_i,
   input  logic [INT_W-1:0]   operand_i,
   output logic [WORD_W-1:0]  word_o,
   output logic               zero_o
);

   localparam int LZ_W = $clog2(INT_W) + 1;
   localparam int HALF = INT_W / 2;
   localparam int BIAS = (1 << (EXP_W - 1)) - 1;

   initial begin
      sig_fit_chk: assert (SIG_W >= INT_W)
         else $error("ixl_int_convert: significand too narrow for exact conversion");
      exp_fit_chk: assert (EXP_W >= 8)
         else $error("ixl_int_convert: exponent too narrow");
   end

   logic [INT_W-1:0] ext;
   logic [INT_W-1:0] mag;
   logic             neg;
   logic [LZ_W-1:0]  lz;
   logic [INT_W-1:0] norm;
   logic [SIG_W-1:0] sig;
   logic [EXP_W-1:0] expo;

   // sign extension to the full integer width
   always_comb begin
      case (size_i)
         SZ_W16:  ext = {{(INT_W-16){operand_i[15]}}, operand_i[15:0]};
         SZ_W32:  ext = {{(INT_W-32){operand_i[31]}}, operand_i[31:0]};
         default: ext = operand_i;
      endcase
   end

   assign neg = ext[INT_W-1];
   // unsigned magnitude; the most negative value maps to 2^(INT_W-1)
   assign mag = neg ? (~ext + INT_W'(1)) : ext;

   generate
      if (LZC_SPLIT) begin : g_lzc_split
         function automatic logic [LZ_W-1:0] half_lz(input logic [HALF-1:0] v);
            logic [LZ_W-1:0] n;
            logic            hit;
            n   = '0;
            hit = 1'b0;
            for (int i = HALF - 1; i >= 0; i--) begin
               if (!hit) begin
                  if (v[i]) hit = 1'b1;
                  else      n   = n + LZ_W'(1);
               end
            end
            return n;
         endfunction

         logic [HALF-1:0] upper;
         logic [HALF-1:0] lower;
         assign upper = mag[INT_W-1:HALF];
         assign lower = mag[HALF-1:0];
         assign lz = (upper != '0) ? half_lz(upper)
                                   : LZ_W'(HALF) + half_lz(lower);
      end else begin : g_lzc_chain
         function automatic logic [LZ_W-1:0] full_lz(input logic [INT_W-1:0] v);
            logic [LZ_W-1:0] n;
            logic            hit;
            n   = '0;
            hit = 1'b0;
            for (int i = INT_W - 1; i >= 0; i--) begin
               if (!hit) begin
                  if (v[i]) hit = 1'b1;
                  else      n   = n + LZ_W'(1);
               end
            end
            return n;
         endfunction

         assign lz = full_lz(mag);
      end
   endgenerate

   assign norm = mag << lz;
   assign expo = EXP_W'(BIAS + INT_W - 1) - EXP_W'(lz);

   generate
      if (SIG_W == INT_W) begin : g_sig_same
         assign sig = norm;
      end else begin : g_sig_pad
         assign sig = {norm, {(SIG_W-INT_W){1'b0}}};
      end
   endgenerate

   assign zero_o = (mag == '0);
   assign word_o = zero_o ? '0 : {neg, expo, sig};

   // R3
   always_comb begin
      if (!zero_o) begin
         norm_msb_chk: assert (word_o[SIG_W-1] == 1'b1);
      end
   end

endmodule

// File: rtl/ixl_reg_stack.sv
module ixl_reg_stack
   import ixl_pkg::*;
#(
   parameter int NREGS    = 8,
   parameter int EXP_W    = 15,
   parameter int SIG_W    = 64,
   localparam int PTR_W   = $clog2(NREGS),
   localparam int WORD_W  = 1 + EXP_W + SIG_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      push_i,
   input  logic [WORD_W-1:0]         din_i,
   input  logic                      din_zero_i,
   output logic [PTR_W-1:0]          top_o,
   output logic                      c1_o,
   output logic                      fault_o,
   output logic [2*NREGS-1:0]        tags_o,
   output logic [NREGS*WORD_W-1:0]   regs_o
);

   localparam logic [WORD_W-1:0] INDEF =
      {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

   initial begin
      depth_pow2_chk: assert (NREGS >= 2 && (1 << PTR_W) == NREGS)
         else $error("ixl_reg_stack: depth must be a power of two");
   end

   logic [PTR_W-1:0]  top_q;
   logic              c1_q;
   logic              fault_q;
   logic [PTR_W-1:0]  new_top;
   logic              ovf;
   logic [WORD_W-1:0] wdata;
   logic [1:0]        wtag;
   logic [WORD_W-1:0] rd_regs [NREGS];
   logic [1:0]        rd_tags [NREGS];

   assign new_top = top_q - PTR_W'(1);
   assign ovf     = (rd_tags[new_top] != TAG_EMPTY);
   assign wdata   = ovf ? INDEF : din_i;
   assign wtag    = (ovf || !din_zero_i) ? TAG_VALID : TAG_ZERO;

   generate
      for (genvar i = 0; i < NREGS; i++) begin : g_reg
         logic [WORD_W-1:0] r_q;
         logic [1:0]        t_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               r_q <= '0;
               t_q <= TAG_EMPTY;
            end else if (push_i && new_top == PTR_W'(i)) begin
               r_q <= wdata;
               t_q <= wtag;
            end
         end

         assign rd_regs[i]                    = r_q;
         assign rd_tags[i]                    = t_q;
         assign regs_o[i*WORD_W +: WORD_W]    = r_q;
         assign tags_o[2*i +: 2]              = t_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q   <= '0;
         c1_q    <= 1'b0;
         fault_q <= 1'b0;
      end else if (push_i) begin
         top_q   <= new_top;
         c1_q    <= ovf;
         fault_q <= ovf;
      end else begin
         fault_q <= 1'b0;
      end
   end

   assign top_o   = top_q;
   assign c1_o    = c1_q;
   assign fault_o = fault_q;

   // R7
   top_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> top_q == ($past(top_q) - PTR_W'(1)));

   // R9
   fault_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_q |-> c1_q);

   // R9
   ovf_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && ovf) |=> rd_regs[$past(new_top)] == INDEF);

   // R8
   tag_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |=> rd_tags[$past(new_top)] != TAG_EMPTY);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !push_i |=> $stable(top_q) && $stable(c1_q) && !fault_q);

endmodule

// File: rtl/int2ext_loader.sv
module int2ext_loader
   import ixl_pkg::*;
#(
   parameter int  NREGS     = 8,
   parameter int  EXP_W     = 15,
   parameter int  SIG_W     = 64,
   parameter bit  LZC_SPLIT = 1'b1,
   localparam int PTR_W     = $clog2(NREGS),
   localparam int WORD_W    = 1 + EXP_W + SIG_W
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load_i,
   input  logic [7:0]               opcode_i,
   input  logic [2:0]               reg_sel_i,
   input  logic [INT_W-1:0]         operand_i,
   output logic [PTR_W-1:0]         top_o,
   output logic                     c1_o,
   output logic                     stack_fault_o,
   output logic [2*NREGS-1:0]       tags_o,
   output logic [NREGS*WORD_W-1:0]  regs_o
);

   isize_e            size;
   logic              push;
   logic [WORD_W-1:0] conv_word;
   logic              conv_zero;

   ixl_size_decode u_dec (
      .opcode_i (opcode_i),
      .field_i  (reg_sel_i),
      .size_o   (size)
   );

   ixl_int_convert #(
      .EXP_W     (EXP_W),
      .SIG_W     (SIG_W),
      .LZC_SPLIT (LZC_SPLIT)
   ) u_conv (
      .size_i    (size),
      .operand_i (operand_i),
      .word_o    (conv_word),
      .zero_o    (conv_zero)
   );

   assign push = load_i && (size != SZ_NONE);

   ixl_reg_stack #(
      .NREGS (NREGS),
      .EXP_W (EXP_W),
      .SIG_W (SIG_W)
   ) u_stk (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push),
      .din_i      (conv_word),
      .din_zero_i (conv_zero),
      .top_o      (top_o),
      .c1_o       (c1_o),
      .fault_o    (stack_fault_o),
      .tags_o     (tags_o),
      .regs_o     (regs_o)
   );

   // R2
   bad_opcode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load_i && size == SZ_NONE) |=>
         $stable(top_o) && $stable(tags_o) && $stable(c1_o) && !stack_fault_o);

endmodule

// File: tb/sim_int2ext_loader.sv
module sim_int2ext_loader;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         load_i = 1'b0;
   logic [7:0]   opcode_i = '0;
   logic [2:0]   reg_sel_i = '0;
   logic [63:0]  operand_i = '0;
   logic [2:0]   top_o;
   logic         c1_o;
   logic         stack_fault_o;
   logic [15:0]  tags_o;
   logic [639:0] regs_o;

   int2ext_loader u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (load_i),
      .opcode_i      (opcode_i),
      .reg_sel_i     (reg_sel_i),
      .operand_i     (operand_i),
      .top_o         (top_o),
      .c1_o          (c1_o),
      .stack_fault_o (stack_fault_o),
      .tags_o        (tags_o),
      .regs_o        (regs_o)
   );

   always #10 clk = ~clk;

   typedef struct {
      int           due;
      logic [2:0]   top;
      logic [15:0]  tags;
      logic [639:0] regs;
      logic         c1;
      logic         fault;
      string        req;
   } item_t;

   item_t       sb_q[$];
   int          cyc = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 1'b0;

   logic [2:0]  m_top;
   logic [1:0]  m_tag [8];
   logic [79:0] m_reg [8];
   logic        m_c1;
   logic        m_fault;

   localparam logic [79:0] INDEF_W = 80'hFFFF_C000_0000_0000_0000;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic model_reset();
      m_top = '0;
      m_c1 = 1'b0;
      m_fault = 1'b0;
      for (int i = 0; i < 8; i++) begin
         m_tag[i] = 2'b11;
         m_reg[i] = '0;
      end
   endtask

   // exact conversion computed from R1/R3/R5
   task automatic conv(input int sz, input logic [63:0] op,
                       output logic [79:0] w, output logic z);
      logic [63:0] v;
      logic [63:0] mag;
      int          msb;
      if (sz == 16)      v = {{48{op[15]}}, op[15:0]};
      else if (sz == 32) v = {{32{op[31]}}, op[31:0]};
      else               v = op;
      mag = v[63] ? (64'd0 - v) : v;
      msb = -1;
      for (int i = 0; i < 64; i++) if (mag[i]) msb = i;
      z = (msb < 0);
      if (z) w = '0;
      else   w = {v[63], 15'(16383 + msb), mag << (63 - msb)};
   endtask

   task automatic drive(input logic ld, input logic [7:0] opc,
                        input logic [2:0] fld, input logic [63:0] val,
                        input string req);
      item_t       it;
      int          sz;
      logic [79:0] w;
      logic        z;
      logic [2:0]  nt;
      logic        ovf;
      @(negedge clk);
      load_i    = ld;
      opcode_i  = opc;
      reg_sel_i = fld;
      operand_i = val;
      sz = 0;
      if (opc == 8'hDF && fld == 3'd0)      sz = 16;
      else if (opc == 8'hDB && fld == 3'd0) sz = 32;
      else if (opc == 8'hDF && fld == 3'd5) sz = 64;
      m_fault = 1'b0;
      if (ld && sz != 0) begin
         conv(sz, val, w, z);
         nt  = m_top - 3'd1;
         ovf = (m_tag[nt] != 2'b11);
         if (ovf) begin
            w = INDEF_W;
            m_tag[nt] = 2'b00;
         end else begin
            m_tag[nt] = z ? 2'b01 : 2'b00;
         end
         m_reg[nt] = w;
         m_top     = nt;
         m_c1      = ovf;
         m_fault   = ovf;
      end
      it.due   = cyc + 1;
      it.top   = m_top;
      it.c1    = m_c1;
      it.fault = m_fault;
      it.req   = req;
      for (int i = 0; i < 8; i++) begin
         it.tags[2*i +: 2]  = m_tag[i];
         it.regs[80*i +: 80] = m_reg[i];
      end
      sb_q.push_back(it);
   endtask

   task automatic idle(input string req);
      drive(1'b0, 8'h00, 3'd0, 64'd0, req);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [639:0] act, input logic [639:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // monitor: compare each item in the cycle it is due
   always @(negedge clk) begin
      item_t it;
      if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
         it = sb_q.pop_front();
         chk(it.req, "top",   640'(top_o),         640'(it.top));
         chk(it.req, "tags",  640'(tags_o),        640'(it.tags));
         chk(it.req, "regs",  regs_o,              it.regs);
         chk(it.req, "c1",    640'(c1_o),          640'(it.c1));
         chk(it.req, "fault", 640'(stack_fault_o), 640'(it.fault));
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n  = 1'b0;
      load_i = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      model_reset();
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      model_reset();
      do_reset();
      idle("R6");                                          // reset state
      drive(1, 8'hDF, 3'd0, 64'h0000_0000_0000_0001, "R1");  // 16-bit +1
      drive(1, 8'hDF, 3'd0, 64'h1234_5678_9ABC_8000, "R4");  // -32768, junk above
      drive(1, 8'hDB, 3'd0, 64'hFFFF_FFFF_0000_0000, "R5");  // 32-bit zero
      drive(1, 8'hDB, 3'd0, 64'hDEAD_BEEF_FFFF_FFFF, "R1");  // 32-bit -1
      drive(1, 8'hDB, 3'd5, 64'h0000_0000_0000_0042, "R2");  // ignored pair
      drive(1, 8'hDF, 3'd3, 64'h0000_0000_0000_0042, "R2");  // ignored pair
      idle("R11");
      drive(1, 8'hDF, 3'd5, 64'h8000_0000_0000_0000, "R4");  // -2^63
      drive(1, 8'hDF, 3'd5, 64'h7FFF_FFFF_FFFF_FFFF, "R3");
      drive(1, 8'hDF, 3'd0, 64'h0000_0000_0000_7FFF, "R7");
      drive(1, 8'hDB, 3'd0, 64'h0000_0000_8000_0000, "R8");  // stack now full
      drive(1, 8'hDF, 3'd5, 64'h0000_0000_0000_007B, "R9");  // overflow
      idle("R9");                                            // fault falls, c1 held
      drive(1, 8'hDB, 3'd0, 64'h0000_0000_0000_0005, "R9");  // overflow again
      drive(1, 8'hDF, 3'd3, 64'h0000_0000_0000_0005, "R2");  // ignored while full
      do_reset();
      idle("R6");
      drive(1, 8'hDF, 3'd5, 64'h0000_0000_0000_0000, "R5");  // 64-bit zero
      drive(1, 8'hDB, 3'd0, 64'h0000_0000_0000_0300, "R10");
      idle("R11");
      @(negedge clk);
      load_i = 1'b0;
      repeat (3) @(negedge clk);
      if (sb_q.size() != 0) begin
         n_chk++;
         n_fail++;
         $display("FAIL scoreboard: actual=%0d pending expected=0", sb_q.size());
      end
      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule